// File: doc/BRIEF.md
# Transfer Descriptor Completion Engine

This block applies the host-controller completion rules to one transfer descriptor. An outer list scheduler presents the descriptor's 32-bit control word and its token word, together with the transaction result from the device side: a one-hot outcome vector and the number of bytes the device returned. It then pulses `start`. One clock later the engine raises `done` for a single cycle. At that point it presents the rewritten control word, a 2-bit interrupt-cause mask, two controller-status flags and a 2-bit return code.

The engine does not touch memory and drives no bus. It decodes the token into packet ID, device address, endpoint and maximum length. It limits the returned length and runs the 2-bit retry counter. It then decides whether the scheduler should advance the queue, skip the descriptor, abort the frame or wait for an asynchronous completion. The scheduler compares `ctrl_out` with the word it fetched and writes it back only when the two differ.

Return code encoding on `rc`: 0 = completed (advance the queue), 1 = not successful or inactive, 2 = abort the frame, 3 = pending.

Top module: `td_status_engine`

## Requirements
- R1: The token decodes as packet ID = token[7:0], device address = token[14:8] and endpoint = token[18:15]. The maximum length is (token[31:21] + 1) modulo 2048, so an all-ones field gives 0. Recognised IDs are IN 0x69, OUT 0xE1 and SETUP 0x2D.
- R2: Whenever `done` is high, `irq_mask[0]` equals the descriptor's interrupt-on-complete bit (control bit 24), whatever the outcome.
- R3: A descriptor whose active bit (control bit 23) is clear is not executed. `ctrl_out` equals `ctrl_in` and `rc` is 1.
- R4: An active descriptor with an unrecognised packet ID raises `sts_hc_err`, returns `rc` 2 and leaves the control word unchanged.
- R5: A pending outcome (result bit 4) returns `rc` 3, leaves the control word unchanged and raises no status flag.
- R6: On success, control bits [10:0] receive (length − 1) modulo 2048, and the active bit and the NAK bit (bit 19) are cleared. The result is `rc` 0. OUT and SETUP report the maximum length; IN reports the returned length.
- R7: An IN whose returned length exceeds the maximum is babble. It sets the babble bit (20) and the stall bit (22), clears active, leaves bits [10:0] unchanged and returns `rc` 2.
- R8: A successful IN with short-packet-detect (bit 29) set and a length below the maximum sets `irq_mask[1]` and returns `rc` 1. Without bit 29 the same transfer returns `rc` 0.
- R9: A timeout (result bit 3, or no result bit set) sets the timeout bit (18). A nonzero error counter in bits [28:27] is decremented. If it reaches zero, active is cleared and `sts_usb_err` rises. A zero counter stays zero and active stays set. The result is `rc` 1.
- R10: A NAK (result bit 1) sets bit 19 and returns `rc` 1 with active kept. A NAK on SETUP additionally follows the timeout path of R9.
- R11: A stall (result bit 2) sets bit 22, clears active and returns `rc` 1.
- R12: When isochronous-select (bit 25) is set, active is cleared for every executed outcome except pending.
- R13: `done` is high exactly in the cycle after `start`. All outputs are registered and hold between strobes. If several result bits are set, the priority is pending, ok, NAK, stall, timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Evaluate the presented descriptor |
| ctrl_in | input | 32 | Descriptor control/status word |
| token_in | input | 32 | Descriptor token word |
| xact_res | input | 5 | Outcome: bit0 ok, bit1 NAK, bit2 stall, bit3 timeout/no device, bit4 pending |
| rx_len | input | 11 | Bytes returned by the device for IN |
| done | output | 1 | One-cycle completion pulse |
| ctrl_out | output | 32 | Rewritten control word |
| irq_mask | output | 2 | bit0 completion interrupt, bit1 short-packet interrupt |
| rc | output | 2 | Return code |
| sts_hc_err | output | 1 | Host process error (bad packet ID) |
| sts_usb_err | output | 1 | Retry counter exhausted |
| pkt_id | output | 8 | Decoded packet ID |
| dev_addr | output | 7 | Decoded device address |
| endpt | output | 4 | Decoded endpoint |
| max_len | output | 11 | Decoded maximum length |

## Verification
Two pairs of functions can act in the same evaluation. The first pair is the completion interrupt and the short-packet interrupt. A short IN with both bit 24 and bit 29 set must yield a mask of 3 and `rc` 1. The second pair is the isochronous-select clear and retry exhaustion. A timeout with bit 25 set and a counter of 1 must clear active once, zero the counter and raise `sts_usb_err` in the same `done` cycle. Both cases are judged against control words computed by hand from the requirements.

// File: rtl/td_eng_pkg.sv
package td_eng_pkg;
  localparam int CW     = 32;
  localparam int LEN_W  = 11;
  localparam int PID_W  = 8;
  localparam int ADDR_W = 7;
  localparam int EP_W   = 4;
  localparam int RES_W  = 5;

  // control word bit positions
  localparam int B_TMO   = 18;
  localparam int B_NAK   = 19;
  localparam int B_BAB   = 20;
  localparam int B_STALL = 22;
  localparam int B_ACT   = 23;
  localparam int B_IOC   = 24;
  localparam int B_ISO   = 25;
  localparam int B_ERRLO = 27;
  localparam int B_ERRHI = 28;
  localparam int B_SPD   = 29;

  // token field positions
  localparam int T_ADDR_LO = PID_W;
  localparam int T_EP_LO   = T_ADDR_LO + ADDR_W;
  localparam int T_LEN_LO  = CW - LEN_W;

  localparam logic [PID_W-1:0] PID_IN    = 8'h69;
  localparam logic [PID_W-1:0] PID_OUT   = 8'hE1;
  localparam logic [PID_W-1:0] PID_SETUP = 8'h2D;

  typedef enum logic [1:0] {RC_DONE = 2'd0, RC_SKIP = 2'd1, RC_ABORT = 2'd2, RC_PEND = 2'd3} td_rc_e;
  typedef enum logic [1:0] {PK_IN, PK_OUT, PK_SETUP, PK_BAD} pid_kind_e;
  typedef enum logic [2:0] {X_OK, X_NAK, X_STALL, X_TMO, X_PEND} xact_e;
endpackage

// File: rtl/td_token_decode.sv
module td_token_decode
  import td_eng_pkg::*;
(
  input  logic [CW-1:0]     token,
  output logic [PID_W-1:0]  pid,
  output logic [ADDR_W-1:0] addr,
  output logic [EP_W-1:0]   ep,
  output logic [LEN_W-1:0]  max_len,
  output pid_kind_e         kind
);
  logic rsvd_unused;

  assign pid     = token[PID_W-1:0];
  assign addr    = token[T_ADDR_LO +: ADDR_W];
  assign ep      = token[T_EP_LO +: EP_W];
  assign max_len = token[T_LEN_LO +: LEN_W] + LEN_W'(1);
  assign rsvd_unused = ^token[T_LEN_LO-1:T_EP_LO+EP_W];

  always_comb begin
    if (pid == PID_IN)         kind = PK_IN;
    else if (pid == PID_OUT)   kind = PK_OUT;
    else if (pid == PID_SETUP) kind = PK_SETUP;
    else                       kind = PK_BAD;
  end
endmodule

// File: rtl/td_result_select.sv
module td_result_select
  import td_eng_pkg::*;
(
  input  logic [RES_W-1:0] res,
  output xact_e            xact
);
  always_comb begin
    if (res[4])      xact = X_PEND;
    else if (res[0]) xact = X_OK;
    else if (res[1]) xact = X_NAK;
    else if (res[2]) xact = X_STALL;
    else             xact = X_TMO;
  end
endmodule

// File: rtl/td_length_resolve.sv
module td_length_resolve
  import td_eng_pkg::*;
(
  input  pid_kind_e        kind,
  input  logic [LEN_W-1:0] max_len,
  input  logic [LEN_W-1:0] rx_len,
  output logic [LEN_W-1:0] xfer_len,
  output logic             babble,
  output logic             short_pkt
);
  always_comb begin
    xfer_len  = max_len;
    babble    = 1'b0;
    short_pkt = 1'b0;
    if (kind == PK_IN) begin
      if (rx_len > max_len) begin
        babble = 1'b1;
      end else begin
        xfer_len  = rx_len;
        short_pkt = (rx_len < max_len);
      end
    end
  end
endmodule

// File: rtl/td_ctrl_update.sv
module td_ctrl_update
  import td_eng_pkg::*;
(
  input  logic [CW-1:0]    ctrl_in,
  input  pid_kind_e        kind,
  input  xact_e            xact,
  input  logic [LEN_W-1:0] xfer_len,
  input  logic             babble,
  input  logic             short_pkt,
  output logic [CW-1:0]    ctrl_nxt,
  output logic [1:0]       mask_nxt,
  output td_rc_e           rc_nxt,
  output logic             hc_err_nxt,
  output logic             usb_err_nxt
);
  localparam int ERR_W = B_ERRHI - B_ERRLO + 1;

  logic [ERR_W-1:0] err_cnt, err_new;
  logic             tmo_path;

  always_comb begin
    ctrl_nxt    = ctrl_in;
    mask_nxt    = {1'b0, ctrl_in[B_IOC]};
    rc_nxt      = RC_SKIP;
    hc_err_nxt  = 1'b0;
    usb_err_nxt = 1'b0;
    tmo_path    = 1'b0;
    err_cnt     = ctrl_in[B_ERRHI:B_ERRLO];
    err_new     = err_cnt;
    if (!ctrl_in[B_ACT]) begin
      rc_nxt = RC_SKIP;
    end else if (kind == PK_BAD) begin
      hc_err_nxt = 1'b1;
      rc_nxt     = RC_ABORT;
    end else if (xact == X_PEND) begin
      rc_nxt = RC_PEND;
    end else begin
      if (ctrl_in[B_ISO]) ctrl_nxt[B_ACT] = 1'b0;
      case (xact)
        X_OK: begin
          if (babble) begin
            ctrl_nxt[B_BAB]   = 1'b1;
            ctrl_nxt[B_STALL] = 1'b1;
            ctrl_nxt[B_ACT]   = 1'b0;
            rc_nxt            = RC_ABORT;
          end else begin
            ctrl_nxt[LEN_W-1:0] = xfer_len - LEN_W'(1);
            ctrl_nxt[B_ACT]     = 1'b0;
            ctrl_nxt[B_NAK]     = 1'b0;
            if (kind == PK_IN && ctrl_in[B_SPD] && short_pkt) begin
              mask_nxt[1] = 1'b1;
              rc_nxt      = RC_SKIP;
            end else begin
              rc_nxt = RC_DONE;
            end
          end
        end
        X_NAK: begin
          ctrl_nxt[B_NAK] = 1'b1;
          tmo_path        = (kind == PK_SETUP);
        end
        X_STALL: begin
          ctrl_nxt[B_STALL] = 1'b1;
          ctrl_nxt[B_ACT]   = 1'b0;
        end
        default: tmo_path = 1'b1;
      endcase
      if (tmo_path) begin
        ctrl_nxt[B_TMO] = 1'b1;
        if (err_cnt != '0) begin
          err_new = err_cnt - ERR_W'(1);
          if (err_new == '0) begin
            ctrl_nxt[B_ACT] = 1'b0;
            usb_err_nxt     = 1'b1;
          end
        end
        ctrl_nxt[B_ERRHI:B_ERRLO] = err_new;
      end
    end
  end
endmodule

// File: rtl/td_status_engine.sv
module td_status_engine
  import td_eng_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CW-1:0]     ctrl_in,
  input  logic [CW-1:0]     token_in,
  input  logic [RES_W-1:0]  xact_res,
  input  logic [LEN_W-1:0]  rx_len,
  output logic              done,
  output logic [CW-1:0]     ctrl_out,
  output logic [1:0]        irq_mask,
  output logic [1:0]        rc,
  output logic              sts_hc_err,
  output logic              sts_usb_err,
  output logic [PID_W-1:0]  pkt_id,
  output logic [ADDR_W-1:0] dev_addr,
  output logic [EP_W-1:0]   endpt,
  output logic [LEN_W-1:0]  max_len
);
  logic [PID_W-1:0]  pid_w;
  logic [ADDR_W-1:0] addr_w;
  logic [EP_W-1:0]   ep_w;
  logic [LEN_W-1:0]  max_w, xfer_w;
  pid_kind_e         kind_w;
  xact_e             xact_w;
  logic              babble_w, short_w;
  logic [CW-1:0]     ctrl_w;
  logic [1:0]        mask_w;
  td_rc_e            rc_w;
  logic              hc_err_w, usb_err_w;

  td_token_decode u_dec (
    .token(token_in), .pid(pid_w), .addr(addr_w), .ep(ep_w),
    .max_len(max_w), .kind(kind_w)
  );

  td_result_select u_sel (.res(xact_res), .xact(xact_w));

  td_length_resolve u_len (
    .kind(kind_w), .max_len(max_w), .rx_len(rx_len),
    .xfer_len(xfer_w), .babble(babble_w), .short_pkt(short_w)
  );

  td_ctrl_update u_upd (
    .ctrl_in(ctrl_in), .kind(kind_w), .xact(xact_w), .xfer_len(xfer_w),
    .babble(babble_w), .short_pkt(short_w), .ctrl_nxt(ctrl_w),
    .mask_nxt(mask_w), .rc_nxt(rc_w), .hc_err_nxt(hc_err_w),
    .usb_err_nxt(usb_err_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done        <= 1'b0;
      ctrl_out    <= '0;
      irq_mask    <= '0;
      rc          <= '0;
      sts_hc_err  <= 1'b0;
      sts_usb_err <= 1'b0;
      pkt_id      <= '0;
      dev_addr    <= '0;
      endpt       <= '0;
      max_len     <= '0;
    end else begin
      done <= start;
      if (start) begin
        ctrl_out    <= ctrl_w;
        irq_mask    <= mask_w;
        rc          <= rc_w;
        sts_hc_err  <= hc_err_w;
        sts_usb_err <= usb_err_w;
        pkt_id      <= pid_w;
        dev_addr    <= addr_w;
        endpt       <= ep_w;
        max_len     <= max_w;
      end
    end
  end

  assert_done_after_start_R13: assert property (@(posedge clk) disable iff (rst)
    start |=> done);
  assert_done_only_after_start_R13: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(start));
  assert_ioc_mask_R2: assert property (@(posedge clk) disable iff (rst)
    done |-> irq_mask[0] == $past(ctrl_in[B_IOC]));
  assert_inactive_untouched_R3: assert property (@(posedge clk) disable iff (rst)
    (done && !$past(ctrl_in[B_ACT])) |-> (rc == RC_SKIP && ctrl_out == $past(ctrl_in)));
  assert_hc_err_aborts_R4: assert property (@(posedge clk) disable iff (rst)
    (done && sts_hc_err) |-> (rc == RC_ABORT && ctrl_out == $past(ctrl_in)));
  assert_pending_untouched_R5: assert property (@(posedge clk) disable iff (rst)
    (done && rc == RC_PEND) |-> (ctrl_out == $past(ctrl_in) && !sts_usb_err && !sts_hc_err));
  assert_success_clears_R6: assert property (@(posedge clk) disable iff (rst)
    (done && rc == RC_DONE) |-> (!ctrl_out[B_ACT] && !ctrl_out[B_NAK]));
  assert_usb_err_retires_R9: assert property (@(posedge clk) disable iff (rst)
    (done && sts_usb_err) |-> (!ctrl_out[B_ACT] && ctrl_out[B_TMO] && ctrl_out[B_ERRHI:B_ERRLO] == 2'd0));
  assert_short_irq_skip_R8: assert property (@(posedge clk) disable iff (rst)
    (done && irq_mask[1]) |-> (rc == RC_SKIP && $past(ctrl_in[B_SPD])));
endmodule

// File: tb/td_status_engine_tb_top.sv
module td_status_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [31:0] ctrl_in, token_in;
  logic [4:0]  xact_res;
  logic [10:0] rx_len;
  logic        done;
  logic [31:0] ctrl_out;
  logic [1:0]  irq_mask, rc;
  logic        sts_hc_err, sts_usb_err;
  logic [7:0]  pkt_id;
  logic [6:0]  dev_addr;
  logic [3:0]  endpt;
  logic [10:0] max_len;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  localparam logic [31:0] ACT = 32'h0080_0000, IOC = 32'h0100_0000, ISO = 32'h0200_0000;
  localparam logic [31:0] SPD = 32'h2000_0000, NAK = 32'h0008_0000, TMO = 32'h0004_0000;
  localparam logic [31:0] BAB = 32'h0010_0000, STL = 32'h0040_0000;
  localparam logic [31:0] E1 = 32'h0800_0000, E2 = 32'h1000_0000, E3 = 32'h1800_0000;
  localparam logic [4:0]  R_OK = 5'b00001, R_NAK = 5'b00010, R_STL = 5'b00100;
  localparam logic [4:0]  R_TMO = 5'b01000, R_PND = 5'b10000, R_NONE = 5'b00000;
  localparam logic [7:0]  P_IN = 8'h69, P_OUT = 8'hE1, P_SET = 8'h2D;

  always #10 clk = ~clk;

  td_status_engine dut_i (
    .clk(clk), .rst(rst), .start(start), .ctrl_in(ctrl_in), .token_in(token_in),
    .xact_res(xact_res), .rx_len(rx_len), .done(done), .ctrl_out(ctrl_out),
    .irq_mask(irq_mask), .rc(rc), .sts_hc_err(sts_hc_err), .sts_usb_err(sts_usb_err),
    .pkt_id(pkt_id), .dev_addr(dev_addr), .endpt(endpt), .max_len(max_len)
  );

  function automatic logic [31:0] mk_tok(input int mx, input int ad, input int ep, input logic [7:0] pid);
    logic [10:0] f;
    f = 11'(mx - 1);
    return {f, 2'b00, ep[3:0], ad[6:0], pid};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] c, input logic [31:0] t, input logic [4:0] r, input int n);
    @(negedge clk);
    ctrl_in = c; token_in = t; xact_res = r; rx_len = 11'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic expect_out(input string req, input logic [31:0] c, input logic [1:0] m,
                            input logic [1:0] r, input logic he, input logic ue);
    chk(req, "done", {31'd0, done}, 32'd1);
    chk(req, "ctrl_out", ctrl_out, c);
    chk(req, "irq_mask", {30'd0, irq_mask}, {30'd0, m});
    chk(req, "rc", {30'd0, rc}, {30'd0, r});
    chk(req, "hc_err", {31'd0, sts_hc_err}, {31'd0, he});
    chk(req, "usb_err", {31'd0, sts_usb_err}, {31'd0, ue});
  endtask

  task automatic t_reset;
    chk("R13", "reset done", {31'd0, done}, 32'd0);
    chk("R13", "reset ctrl_out", ctrl_out, 32'd0);
    chk("R13", "reset rc", {30'd0, rc}, 32'd0);
  endtask

  task automatic t_decode_inactive;
    apply(IOC | 32'h55, mk_tok(64, 7'h55, 4'hA, P_IN), R_OK, 10);
    chk("R1", "pid", {24'd0, pkt_id}, 32'h69);
    chk("R1", "addr", {25'd0, dev_addr}, 32'h55);
    chk("R1", "ep", {28'd0, endpt}, 32'hA);
    chk("R1", "max", {21'd0, max_len}, 32'd64);
    expect_out("R3", IOC | 32'h55, 2'b01, 2'd1, 1'b0, 1'b0);
  endtask

  task automatic t_wrap_zero;
    apply(ACT | NAK | 32'h123, mk_tok(0, 1, 1, P_OUT), R_OK, 0);
    chk("R1", "wrap max", {21'd0, max_len}, 32'd0);
    expect_out("R6", 32'h0000_07FF, 2'b00, 2'd0, 1'b0, 1'b0);
  endtask

  task automatic t_out_setup_ok;
    apply(ACT | E3, mk_tok(8, 2, 0, P_OUT), R_OK, 3);
    expect_out("R6", E3 | 32'h7, 2'b00, 2'd0, 1'b0, 1'b0);
    apply(ACT | IOC, mk_tok(8, 2, 0, P_SET), R_OK, 0);
    expect_out("R6", IOC | 32'h7, 2'b01, 2'd0, 1'b0, 1'b0);
  endtask

  task automatic t_in_full;
    apply(ACT | SPD | E3, mk_tok(16, 3, 1, P_IN), R_OK, 16);
    expect_out("R6", SPD | E3 | 32'hF, 2'b00, 2'd0, 1'b0, 1'b0);
  endtask

  task automatic t_short_ioc;
    apply(ACT | SPD | IOC, mk_tok(16, 3, 1, P_IN), R_OK, 4);
    expect_out("R8", SPD | IOC | 32'h3, 2'b11, 2'd1, 1'b0, 1'b0);
    apply(ACT, mk_tok(16, 3, 1, P_IN), R_OK, 4);
    expect_out("R8", 32'h3, 2'b00, 2'd0, 1'b0, 1'b0);
  endtask

  task automatic t_babble;
    apply(ACT | E3 | 32'h7FF, mk_tok(8, 3, 1, P_IN), R_OK, 9);
    expect_out("R7", E3 | 32'h7FF | BAB | STL, 2'b00, 2'd2, 1'b0, 1'b0);
  endtask

  task automatic t_bad_pid;
    apply(ACT | E2, mk_tok(8, 3, 1, 8'hA5), R_OK, 1);
    expect_out("R4", ACT | E2, 2'b00, 2'd2, 1'b1, 1'b0);
  endtask

  task automatic t_pending;
    apply(ACT | ISO | E1, mk_tok(8, 3, 1, P_IN), R_PND | R_OK, 1);
    expect_out("R5", ACT | ISO | E1, 2'b00, 2'd3, 1'b0, 1'b0);
  endtask

  task automatic t_stall;
    apply(ACT | E2, mk_tok(8, 3, 1, P_OUT), R_STL, 0);
    expect_out("R11", E2 | STL, 2'b00, 2'd1, 1'b0, 1'b0);
  endtask

  task automatic t_nak;
    apply(ACT | E3, mk_tok(8, 3, 1, P_IN), R_NAK | R_STL, 0);
    expect_out("R10", ACT | E3 | NAK, 2'b00, 2'd1, 1'b0, 1'b0);
    apply(ACT | E3, mk_tok(8, 3, 1, P_SET), R_NAK, 0);
    expect_out("R10", ACT | E2 | NAK | TMO, 2'b00, 2'd1, 1'b0, 1'b0);
  endtask

  task automatic t_timeout;
    apply(ACT | E1, mk_tok(8, 3, 1, P_OUT), R_TMO, 0);
    expect_out("R9", TMO, 2'b00, 2'd1, 1'b0, 1'b1);
    apply(ACT, mk_tok(8, 3, 1, P_OUT), R_TMO, 0);
    expect_out("R9", ACT | TMO, 2'b00, 2'd1, 1'b0, 1'b0);
    apply(ACT | E2, mk_tok(8, 3, 1, P_IN), R_NONE, 0);
    expect_out("R9", ACT | E1 | TMO, 2'b00, 2'd1, 1'b0, 1'b0);
  endtask

  task automatic t_iso;
    apply(ACT | ISO | E1, mk_tok(8, 3, 1, P_IN), R_TMO, 0);
    expect_out("R12", ISO | TMO, 2'b00, 2'd1, 1'b0, 1'b1);
    apply(ACT | ISO, mk_tok(8, 3, 1, P_IN), R_NAK, 0);
    expect_out("R12", ISO | NAK, 2'b00, 2'd1, 1'b0, 1'b0);
  endtask

  task automatic t_hold;
    apply(ACT | E3, mk_tok(8, 3, 1, P_OUT), R_OK, 0);
    @(negedge clk);
    chk("R13", "done drops", {31'd0, done}, 32'd0);
    chk("R13", "ctrl held", ctrl_out, E3 | 32'h7);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog R13 actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; start = 1'b0; ctrl_in = '0; token_in = '0; xact_res = '0; rx_len = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_decode_inactive();
    t_wrap_zero();
    t_out_setup_ok();
    t_in_full();
    t_short_ioc();
    t_babble();
    t_bad_pid();
    t_pending();
    t_stall();
    t_nak();
    t_timeout();
    t_iso();
    t_hold();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule